// File: doc/BRIEF.md
# Dual Self-Checking Pair Failover Controller

This block supervises two redundant computing pairs, a primary and a backup. Each pair has two lanes that run the same computation in lockstep. Every cycle, each lane presents a data word and a valid strobe. The controller checks that the two lanes of each pair agree. A pair drives the actuator only while its two words match bit for bit.

When a pair disagrees, the controller takes the whole pair down:

- it holds both lanes of that pair in reset;
- it removes that pair's actuator enable;
- it never lets that pair take control again until a global reset.

If the primary pair is lost, control moves to the backup pair on the next clock edge. The backup pair only adds availability; safety comes from each pair checking its own two lanes. If both pairs fail, the block enters a safe state: all enables are off and the output word is zero. Per-pair fault counters and status flags report what happened.

Top module: `dsc_failover`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the outputs are as follows. `act_valid` is 0 and `act_data` is 0. `pair_en` is 2'b11 and `lane_rst` is 4'b0000. `active_pair` is 0, `pair_failed` is 2'b00, `safe_state` is 0 and every field of `mm_count` is 0.
- R2: Lanes are indexed as 2*pair+lane, and lane k's word is `lane_data[k*W +: W]`; pair 0 is the primary and pair 1 is the backup. Suppose both lanes of the controlling pair are valid and their words are equal in some cycle. After the next edge, `act_valid` is 1 and `act_data` holds that word.
- R3: The lanes are compared only when both are valid. A cycle with neither lane valid produces no fault and gives `act_valid`=0 with `act_data`=0 after the edge. So does a shorter run of single-lane valid.
- R4: Suppose both lanes of a pair are valid and their words differ. At the next edge, `pair_failed[p]` rises, `pair_en[p]` falls and both of that pair's `lane_rst` bits rise. No word from that cycle is forwarded: `act_valid` is 0 and `act_data` is 0.
- R5: After the primary has failed, `active_pair` is 1. Agreeing backup words are forwarded, and words from the primary lanes are ignored.
- R6: A run of VALID_TMO consecutive cycles with exactly one lane of a pair valid counts as a mismatch. The pair fails at the edge that ends the VALID_TMO-th cycle. A shorter run that ends with both lanes valid causes no fault.
- R7: A pair's failure is sticky: agreeing words later on never re-admit it. Only `rst` clears it.
- R8: With both pairs failed, `safe_state` is 1, `pair_en` is 2'b00, `act_valid` is 0 and `act_data` is 0, even if the lanes agree.
- R9: Field `mm_count[p*CNT_W +: CNT_W]` adds one at each cycle in which pair p mismatches, including after that pair has failed. It saturates at 2^CNT_W-1.
- R10: A backup mismatch while the primary is healthy fails only the backup. The primary keeps control and keeps forwarding agreeing words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| lane_valid | input | 4 | Valid strobe per lane, index 2*pair+lane |
| lane_data | input | 4*W | Lane words, lane k at bits k*W +: W |
| act_valid | output | 1 | Registered: forwarded word is valid |
| act_data | output | W | Registered actuator word, zero when not valid |
| pair_en | output | 2 | Actuator enable per pair, low once that pair failed |
| lane_rst | output | 4 | Reset/shutdown line per lane |
| active_pair | output | 1 | 1 when the backup pair is in control |
| pair_failed | output | 2 | Sticky failure flag per pair |
| safe_state | output | 1 | Both pairs failed |
| mm_count | output | 2*CNT_W | Saturating mismatch count per pair |

## Verification
The comparison is tried with several lane patterns:

- equal words with both lanes valid, which must be forwarded;
- words that differ, which must fail the pair;
- one lane valid alone, both just under and exactly at the timeout, which separates a slow lane from a dead one;
- neither lane valid.

Differing data on a pair that is not in control, or on a pair that has already failed, shows whether the selection ignores the right lanes. Repeated mismatches on a failed pair drive its counter into saturation. A backup mismatch under a healthy primary separates the loss of the standby pair from a switchover.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        SEL_PRIMARY = 2'd0,
        SEL_BACKUP  = 2'd1,
        SEL_SAFE    = 2'd2
    } sel_e;

    // Control goes to the first pair that has not failed.
    function automatic sel_e pick_sel(input logic fail_pri, input logic fail_bak);
        if (!fail_pri)      return SEL_PRIMARY;
        else if (!fail_bak) return SEL_BACKUP;
        else                return SEL_SAFE;
    endfunction

endpackage

// File: rtl/dsc_pair_monitor.sv
module dsc_pair_monitor #(
    parameter int W         = 16,
    parameter int VALID_TMO = 4,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             va,
    input  logic             vb,
    input  logic [W-1:0]     da,
    input  logic [W-1:0]     db,
    output logic             agree,
    output logic             mismatch,
    output logic             failed,
    output logic [CNT_W-1:0] count
);
    localparam int SW = (VALID_TMO > 1) ? $clog2(VALID_TMO) : 1;
    localparam logic [SW-1:0] SOLO_LAST = SW'(VALID_TMO - 1);

    logic [SW-1:0] solo_q;
    logic          solo;
    logic          data_diff;
    logic          solo_expired;

    assign solo         = va ^ vb;
    assign data_diff    = va && vb && (da != db);
    assign solo_expired = solo && (solo_q == SOLO_LAST);
    assign mismatch     = data_diff || solo_expired;
    assign agree        = va && vb && (da == db);

    always_ff @(posedge clk) begin
        if (rst) begin
            solo_q <= '0;
        end else if (solo && !solo_expired) begin
            solo_q <= solo_q + 1'b1;
        end else begin
            solo_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            failed <= 1'b0;
        end else if (mismatch) begin
            failed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (mismatch && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dsc_out_select.sv
module dsc_out_select
    import dsc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  sel_e         sel,
    input  logic [1:0]   agree,
    input  logic [W-1:0] word_pri,
    input  logic [W-1:0] word_bak,
    output logic         act_valid,
    output logic [W-1:0] act_data
);
    logic         fwd;
    logic [W-1:0] word;

    always_comb begin
        fwd  = 1'b0;
        word = '0;
        case (sel)
            SEL_PRIMARY: begin fwd = agree[0]; word = word_pri; end
            SEL_BACKUP:  begin fwd = agree[1]; word = word_bak; end
            default:     begin fwd = 1'b0;     word = '0;       end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_valid <= 1'b0;
            act_data  <= '0;
        end else begin
            act_valid <= fwd;
            act_data  <= fwd ? word : '0;
        end
    end

endmodule

// File: rtl/dsc_failover.sv
module dsc_failover
    import dsc_pkg::*;
#(
    parameter int W         = 16,
    parameter int VALID_TMO = 4,
    parameter int CNT_W     = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         lane_valid,
    input  logic [4*W-1:0]     lane_data,
    output logic               act_valid,
    output logic [W-1:0]       act_data,
    output logic [1:0]         pair_en,
    output logic [3:0]         lane_rst,
    output logic               active_pair,
    output logic [1:0]         pair_failed,
    output logic               safe_state,
    output logic [2*CNT_W-1:0] mm_count
);
    localparam int NPAIR = 2;

    logic [NPAIR-1:0] agree;
    logic [NPAIR-1:0] mismatch;
    sel_e             sel;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        dsc_pair_monitor #(
            .W         (W),
            .VALID_TMO (VALID_TMO),
            .CNT_W     (CNT_W)
        ) mon_i (
            .clk      (clk),
            .rst      (rst),
            .va       (lane_valid[2*p]),
            .vb       (lane_valid[2*p+1]),
            .da       (lane_data[(2*p)*W +: W]),
            .db       (lane_data[(2*p+1)*W +: W]),
            .agree    (agree[p]),
            .mismatch (mismatch[p]),
            .failed   (pair_failed[p]),
            .count    (mm_count[p*CNT_W +: CNT_W])
        );
        assign pair_en[p]          = ~pair_failed[p];
        assign lane_rst[2*p +: 2]  = {2{pair_failed[p]}};
    end

    assign sel         = pick_sel(pair_failed[0], pair_failed[1]);
    assign active_pair = (sel == SEL_BACKUP);
    assign safe_state  = (sel == SEL_SAFE);

    dsc_out_select #(.W(W)) sel_i (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .agree     (agree),
        .word_pri  (lane_data[0 +: W]),
        .word_bak  (lane_data[2*W +: W]),
        .act_valid (act_valid),
        .act_data  (act_data)
    );

endmodule

// File: rtl/dsc_failover_chk.sv
module dsc_failover_chk #(
    parameter int W     = 16,
    parameter int CNT_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [3:0]         lane_valid,
    input logic [4*W-1:0]     lane_data,
    input logic               act_valid,
    input logic [W-1:0]       act_data,
    input logic [1:0]         pair_en,
    input logic               active_pair,
    input logic [1:0]         pair_failed,
    input logic               safe_state,
    input logic [2*CNT_W-1:0] mm_count
);
    // R2
    pri_fwd_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && act_valid && !active_pair) |->
        ($past(lane_valid[1:0]) == 2'b11 && $past(lane_data[0 +: W]) == $past(lane_data[W +: W])));

    // R5
    bak_fwd_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && act_valid && active_pair) |->
        ($past(lane_valid[3:2]) == 2'b11 && $past(lane_data[2*W +: W]) == $past(lane_data[3*W +: W])));

    // R4
    no_fwd_on_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(pair_failed[0])) |-> (!act_valid && act_data == '0));

    // R7
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pair_failed) == 2'b11) |-> (pair_failed == 2'b11));

    // R8
    safe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        safe_state |-> (!act_valid && act_data == '0 && pair_en == 2'b00));

    // R9
    cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mm_count[0 +: CNT_W] >= $past(mm_count[0 +: CNT_W])));

    // R10
    bak_loss_keeps_pri_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(pair_failed[1]) && !pair_failed[0]) |-> !active_pair);

endmodule

bind dsc_failover dsc_failover_chk #(.W(W), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .lane_valid  (lane_valid),
    .lane_data   (lane_data),
    .act_valid   (act_valid),
    .act_data    (act_data),
    .pair_en     (pair_en),
    .active_pair (active_pair),
    .pair_failed (pair_failed),
    .safe_state  (safe_state),
    .mm_count    (mm_count)
);

// File: tb/dsc_failover_tb.sv
module dsc_failover_tb_top;
    localparam int W     = 16;
    localparam int TMO   = 4;
    localparam int CNT_W = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [3:0]         lane_valid = '0;
    logic [4*W-1:0]     lane_data = '0;
    logic               act_valid;
    logic [W-1:0]       act_data;
    logic [1:0]         pair_en;
    logic [3:0]         lane_rst;
    logic               active_pair;
    logic [1:0]         pair_failed;
    logic               safe_state;
    logic [2*CNT_W-1:0] mm_count;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dsc_failover #(.W(W), .VALID_TMO(TMO), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .lane_valid(lane_valid), .lane_data(lane_data),
        .act_valid(act_valid), .act_data(act_data), .pair_en(pair_en),
        .lane_rst(lane_rst), .active_pair(active_pair), .pair_failed(pair_failed),
        .safe_state(safe_state), .mm_count(mm_count)
    );

    typedef struct packed {
        logic [3:0]  v;
        logic [15:0] d0, d1, d2, d3;
        logic        ev;
        logic [15:0] ed;
        logic [1:0]  ef;
        logic        ea;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{4'b1111, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 1'b1, 16'h1234, 2'b00, 1'b0}, // R2
        '{4'b0011, 16'hAAAA, 16'hAAAA, 16'h5555, 16'h0001, 1'b1, 16'hAAAA, 2'b00, 1'b0}, // R2
        '{4'b0000, 16'h3333, 16'h3333, 16'h0000, 16'h0000, 1'b0, 16'h0000, 2'b00, 1'b0}, // R3
        '{4'b0001, 16'h4444, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 2'b00, 1'b0}, // R3
        '{4'b0011, 16'h00FF, 16'h00FF, 16'h0000, 16'h0000, 1'b1, 16'h00FF, 2'b00, 1'b0}, // R6
        '{4'b0011, 16'h0001, 16'h0002, 16'h0BEE, 16'h0BEE, 1'b0, 16'h0000, 2'b01, 1'b1}, // R4
        '{4'b1111, 16'h7777, 16'h7777, 16'h0BEE, 16'h0BEE, 1'b1, 16'h0BEE, 2'b01, 1'b1}, // R5 R7
        '{4'b1100, 16'h0000, 16'h0000, 16'h0C0C, 16'h0C0C, 1'b1, 16'h0C0C, 2'b01, 1'b1}  // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] v, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic [15:0] d);
        lane_valid = v;
        lane_data  = {d, c, b, a};
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        lane_valid = '0;
        lane_data  = '0;
        @(posedge clk); @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic check_reset_state(input string req);
        chk(req, {31'b0, act_valid}, 32'd0);
        chk(req, {16'b0, act_data}, 32'd0);
        chk(req, {30'b0, pair_en}, 32'd3);
        chk(req, {28'b0, lane_rst}, 32'd0);
        chk(req, {31'b0, active_pair}, 32'd0);
        chk(req, {30'b0, pair_failed}, 32'd0);
        chk(req, {31'b0, safe_state}, 32'd0);
        chk(req, {26'b0, mm_count}, 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        check_reset_state("R1 reset");

        for (int i = 0; i < NV; i++) begin
            drive(VT[i].v, VT[i].d0, VT[i].d1, VT[i].d2, VT[i].d3);
            chk("R2/R3/R4/R5 act_valid", {31'b0, act_valid}, {31'b0, VT[i].ev});
            chk("R2/R3/R4/R5 act_data", {16'b0, act_data}, {16'b0, VT[i].ed});
            chk("R4/R7 pair_failed", {30'b0, pair_failed}, {30'b0, VT[i].ef});
            chk("R5 active_pair", {31'b0, active_pair}, {31'b0, VT[i].ea});
        end
        chk("R4 lane_rst", {28'b0, lane_rst}, 32'h3);
        chk("R4 pair_en", {30'b0, pair_en}, 32'h2);

        // R9: a failed primary keeps counting and then saturates at 7
        for (int i = 0; i < 6; i++) drive(4'b0011, 16'h1, 16'h2, 16'h0, 16'h0);
        chk("R9 count reaches max", {29'b0, mm_count[2:0]}, 32'd7);
        chk("R5 failed primary ignored", {31'b0, act_valid}, 32'd0);
        drive(4'b0011, 16'h1, 16'h2, 16'h0, 16'h0);
        drive(4'b0011, 16'h1, 16'h2, 16'h0, 16'h0);
        chk("R9 count saturates", {29'b0, mm_count[2:0]}, 32'd7);
        chk("R9 backup count untouched", {29'b0, mm_count[5:3]}, 32'd0);

        // R8: the backup fails as well
        drive(4'b1100, 16'h0, 16'h0, 16'h0001, 16'h0002);
        chk("R8 safe_state", {31'b0, safe_state}, 32'd1);
        chk("R8 pair_en", {30'b0, pair_en}, 32'd0);
        chk("R8 lane_rst", {28'b0, lane_rst}, 32'hF);
        chk("R8 act_valid", {31'b0, act_valid}, 32'd0);
        drive(4'b1111, 16'h5A5A, 16'h5A5A, 16'h5A5A, 16'h5A5A);
        chk("R8 agree ignored valid", {31'b0, act_valid}, 32'd0);
        chk("R8 agree ignored data", {16'b0, act_data}, 32'd0);
        chk("R7 no readmission", {30'b0, pair_failed}, 32'd3);

        // R7: only the global reset clears the failures
        do_reset();
        check_reset_state("R7 reset clears");

        // R6: exactly VALID_TMO cycles of one lane valid
        for (int i = 0; i < TMO - 1; i++) drive(4'b0001, 16'h9, 16'h0, 16'h0, 16'h0);
        chk("R6 below timeout", {30'b0, pair_failed}, 32'd0);
        drive(4'b0001, 16'h9, 16'h0, 16'h0, 16'h0);
        chk("R6 timeout fails", {30'b0, pair_failed}, 32'd1);
        chk("R6 timeout counted", {29'b0, mm_count[2:0]}, 32'd1);
        chk("R6 timeout not forwarded", {31'b0, act_valid}, 32'd0);

        // R10: the backup fails while the primary is healthy
        do_reset();
        drive(4'b1111, 16'h1111, 16'h1111, 16'h0001, 16'h0002);
        chk("R10 primary forwarded", {16'b0, act_data}, 32'h1111);
        chk("R10 primary valid", {31'b0, act_valid}, 32'd1);
        chk("R10 backup failed", {30'b0, pair_failed}, 32'd2);
        chk("R10 active stays primary", {31'b0, active_pair}, 32'd0);
        chk("R10 pair_en", {30'b0, pair_en}, 32'd1);
        drive(4'b0011, 16'h2222, 16'h2222, 16'h0, 16'h0);
        chk("R10 primary still drives", {16'b0, act_data}, 32'h2222);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule